// File: doc/BRIEF.md
# Remap Tag Buffer

This block is a small fully associative store placed in front of an in-package DRAM cache and the main memory behind it. It holds page mappings that have changed since the per-core translation tables were last refreshed. A mapping is three bits. Bit 2 is the resident flag, set when the page is held in the DRAM cache. Bits 1:0 give the way, which is the page's slot among the pages that share one hash index. A core that moves a page into or out of the DRAM cache writes the page tag and its new mapping here. Every memory request probes the buffer before it goes further. On a hit, the buffered mapping replaces the mapping that the request carried from its translation entry.

When the last free entry is taken, the buffer asks for a table update to be broadcast to all cores, and it holds that request until the update is acknowledged. While it waits, it refuses new writes but keeps answering lookups. The acknowledgement empties the buffer in one cycle, and filling then starts again from empty.

The controller has two states. FILL accepts writes. FLUSH holds the broadcast request and stalls writes. The transition FILL→FLUSH is taken on an accepted write of a new tag into the last free entry. The transition FLUSH→FILL is taken on the acknowledgement, and that same edge clears every entry.

Top module: `remap_tag_buf`

## Requirements
- R1: After reset, every entry is empty, so all lookups miss, `flush_req` is 0 and `wr_ready` is 1.
- R2: A lookup that misses returns `lk_hit`=0 and passes `lk_map_in` to `lk_map_out` in the same cycle.
- R3: A lookup whose tag is held returns `lk_hit`=1 and the stored mapping (bit 2 resident, bits 1:0 way) in the same cycle. At most one entry matches any tag.
- R4: An accepted write becomes visible from the next clock edge. A lookup of the same tag in the write's own cycle returns the old contents.
- R5: A write to a tag that is already held updates that entry in place and takes no new slot.
- R6: An accepted write of a new tag into the last free entry raises `flush_req` from the next edge. `flush_req` then stays high, with `wr_ready` low and the contents frozen, until `flush_ack` arrives.
- R7: Lookups are answered from the buffered contents while the flush is pending.
- R8: `flush_ack` while `flush_req` is high empties every entry at that edge and returns to FILL, so `flush_req` drops and `wr_ready` rises.
- R9: `flush_ack` while `flush_req` is low has no effect on the contents.
- R10: With `lk_valid` low, `lk_hit` is 0 and `lk_map_out` equals `lk_map_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup probe present |
| lk_tag | input | TAG_W | Tag being probed |
| lk_map_in | input | 3 | Mapping carried from the translation entry |
| lk_hit | output | 1 | Probe matched a buffered remap |
| lk_map_out | output | 3 | Resolved mapping |
| wr_valid | input | 1 | Remap write offered |
| wr_tag | input | TAG_W | Tag of the page being remapped |
| wr_map | input | 3 | New mapping |
| wr_ready | output | 1 | Write accepted this cycle when high |
| flush_req | output | 1 | Broadcast of a table update requested |
| flush_ack | input | 1 | Broadcast done; clear the buffer |

## Verification
A lookup result is due in the same cycle as its probe. An accepted write shows up on lookups one edge later. `flush_req` rises one edge after the write that fills the buffer, and the clear is seen one edge after the acknowledgement. The driver applies one cycle of stimulus at the falling edge and pushes the expected outputs for that cycle, which it takes from a reference map updated only after the following rising edge. The monitor compares them 1 ns later, in mid-cycle. Each expectation therefore reflects exactly the edges that have passed.

// File: rtl/rtb_pkg.sv
package rtb_pkg;

    localparam int RTB_WAY_W = 2;
    localparam int RTB_MAP_W = RTB_WAY_W + 1;

    typedef struct packed {
        logic                 cached;
        logic [RTB_WAY_W-1:0] way;
    } rtb_map_t;

    typedef enum logic {
        ST_FILL  = 1'b0,
        ST_FLUSH = 1'b1
    } rtb_state_e;

endpackage

// File: rtl/rtb_prio.sv
module rtb_prio #(
    parameter int N     = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic [IDX_W-1:0] idx,
    output logic             any
);

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
        any = |req;
    end

endmodule

// File: rtl/rtb_cam.sv
module rtb_cam
    import rtb_pkg::*;
#(
    parameter int N     = 16,
    parameter int TAG_W = 20,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic [TAG_W-1:0] wr_tag,
    input  rtb_map_t         wr_map,
    input  logic             wr_en,
    input  logic             clr,
    output logic             lk_any,
    output rtb_map_t         lk_map,
    output logic             wr_hit,
    output logic             last_free,
    output logic [N-1:0]     valid_o,
    output logic [N-1:0]     lk_match_o
);

    logic [N-1:0]     valid;
    logic [TAG_W-1:0] st_tag [N];
    rtb_map_t         st_map [N];

    logic [N-1:0]     lk_match;
    logic [N-1:0]     wr_match;
    logic [N-1:0]     free_vec;
    logic [N-1:0]     free_sel;
    logic [N-1:0]     slot_sel;

    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] wr_idx;
    logic             free_any;
    logic             wr_any;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_entry
            assign lk_match[g] = valid[g] && (st_tag[g] == lk_tag);
            assign wr_match[g] = valid[g] && (st_tag[g] == wr_tag);
            assign free_vec[g] = !valid[g];
            assign free_sel[g] = free_any && (free_idx == IDX_W'(g));

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    valid[g]  <= 1'b0;
                    st_tag[g] <= '0;
                    st_map[g] <= '0;
                end else if (clr) begin
                    valid[g]  <= 1'b0;
                end else if (wr_en && slot_sel[g]) begin
                    valid[g]  <= 1'b1;
                    st_tag[g] <= wr_tag;
                    st_map[g] <= wr_map;
                end
            end
        end
    endgenerate

    rtb_prio #(.N(N)) u_lk_enc (
        .req (lk_match),
        .idx (lk_idx),
        .any (lk_any)
    );

    rtb_prio #(.N(N)) u_wr_enc (
        .req (wr_match),
        .idx (wr_idx),
        .any (wr_any)
    );

    rtb_prio #(.N(N)) u_free_enc (
        .req (free_vec),
        .idx (free_idx),
        .any (free_any)
    );

    always_comb begin
        slot_sel = wr_any ? wr_match : free_sel;
        lk_map   = lk_any ? st_map[lk_idx] : '0;
        if (wr_idx == '0) begin
            wr_hit = wr_any;
        end else begin
            wr_hit = 1'b1;
        end
    end

    assign last_free  = ($countones(free_vec) == 1);
    assign valid_o    = valid;
    assign lk_match_o = lk_match;

endmodule

// File: rtl/rtb_ctrl.sv
module rtb_ctrl
    import rtb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_valid,
    input  logic wr_hit,
    input  logic last_free,
    input  logic flush_ack,
    output logic wr_ready,
    output logic wr_en,
    output logic clr,
    output logic flush_req
);

    rtb_state_e state_q;
    rtb_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: begin
                if (wr_valid && !wr_hit && last_free) begin
                    state_d = ST_FLUSH;
                end
            end
            ST_FLUSH: begin
                if (flush_ack) begin
                    state_d = ST_FILL;
                end
            end
            default: state_d = ST_FILL;
        endcase
    end

    always_comb begin
        wr_ready  = 1'b0;
        flush_req = 1'b0;
        clr       = 1'b0;
        unique case (state_q)
            ST_FILL: begin
                wr_ready = 1'b1;
            end
            ST_FLUSH: begin
                flush_req = 1'b1;
                clr       = flush_ack;
            end
            default: begin
                wr_ready = 1'b0;
            end
        endcase
        wr_en = wr_valid && wr_ready;
    end

endmodule

// File: rtl/remap_tag_buf.sv
module remap_tag_buf
    import rtb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lk_valid,
    input  logic [TAG_W-1:0]     lk_tag,
    input  logic [RTB_MAP_W-1:0] lk_map_in,
    output logic                 lk_hit,
    output logic [RTB_MAP_W-1:0] lk_map_out,
    input  logic                 wr_valid,
    input  logic [TAG_W-1:0]     wr_tag,
    input  logic [RTB_MAP_W-1:0] wr_map,
    output logic                 wr_ready,
    output logic                 flush_req,
    input  logic                 flush_ack
);

    logic             cam_any;
    rtb_map_t         cam_map;
    logic             wr_hit;
    logic             last_free;
    logic             wr_en;
    logic             clr;
    logic [ENTRIES-1:0] valid_vec;
    logic [ENTRIES-1:0] lk_match_vec;

    rtb_cam #(.N(ENTRIES), .TAG_W(TAG_W)) u_cam (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_tag     (lk_tag),
        .wr_tag     (wr_tag),
        .wr_map     (rtb_map_t'(wr_map)),
        .wr_en      (wr_en),
        .clr        (clr),
        .lk_any     (cam_any),
        .lk_map     (cam_map),
        .wr_hit     (wr_hit),
        .last_free  (last_free),
        .valid_o    (valid_vec),
        .lk_match_o (lk_match_vec)
    );

    rtb_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_hit    (wr_hit),
        .last_free (last_free),
        .flush_ack (flush_ack),
        .wr_ready  (wr_ready),
        .wr_en     (wr_en),
        .clr       (clr),
        .flush_req (flush_req)
    );

    always_comb begin
        lk_hit     = lk_valid && cam_any;
        lk_map_out = lk_hit ? RTB_MAP_W'(cam_map) : lk_map_in;
    end

endmodule

// File: rtl/rtb_checker.sv
module rtb_checker #(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         lk_valid,
    input logic         lk_hit,
    input logic         wr_valid,
    input logic         wr_ready,
    input logic         wr_hit,
    input logic         flush_req,
    input logic         flush_ack,
    input logic [N-1:0] valid_vec,
    input logic [N-1:0] lk_match_vec
);

    p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match_vec));

    p_inplace_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && wr_hit) |=> $stable(valid_vec));

    p_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (&valid_vec) |-> flush_req);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && !flush_ack) |=> (flush_req && $stable(valid_vec)));

    p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_req) |-> !wr_ready);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && flush_ack) |=> (valid_vec == '0 && !flush_req));

    p_ack_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_req && flush_ack && !wr_valid) |=> $stable(valid_vec));

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !lk_hit);

endmodule

bind remap_tag_buf rtb_checker #(.N(ENTRIES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_valid     (lk_valid),
    .lk_hit       (lk_hit),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .wr_hit       (wr_hit),
    .flush_req    (flush_req),
    .flush_ack    (flush_ack),
    .valid_vec    (valid_vec),
    .lk_match_vec (lk_match_vec)
);

// File: tb/test_remap_tag_buf.sv
module test_remap_tag_buf;

    localparam int ENTRIES = 16;
    localparam int TAG_W   = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lk_valid = 1'b0;
    logic [TAG_W-1:0] lk_tag = '0;
    logic [2:0]       lk_map_in = '0;
    logic             lk_hit;
    logic [2:0]       lk_map_out;
    logic             wr_valid = 1'b0;
    logic [TAG_W-1:0] wr_tag = '0;
    logic [2:0]       wr_map = '0;
    logic             wr_ready;
    logic             flush_req;
    logic             flush_ack = 1'b0;

    always #5 clk = ~clk;

    remap_tag_buf #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) i_remap_tag_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_valid   (lk_valid),
        .lk_tag     (lk_tag),
        .lk_map_in  (lk_map_in),
        .lk_hit     (lk_hit),
        .lk_map_out (lk_map_out),
        .wr_valid   (wr_valid),
        .wr_tag     (wr_tag),
        .wr_map     (wr_map),
        .wr_ready   (wr_ready),
        .flush_req  (flush_req),
        .flush_ack  (flush_ack)
    );

    typedef struct {
        string      rq;
        bit         hit;
        logic [2:0] map;
        bit         flush;
        bit         ready;
    } exp_t;

    exp_t       sb [$];
    event       sample_ev;
    int         total = 0;
    int         bad = 0;
    bit         done = 0;

    logic [2:0] model [int];
    bit         m_flush = 0;

    task automatic step(input string rq, input bit lv, input int lt, input logic [2:0] lm,
                        input bit wv, input int wt, input logic [2:0] wm, input bit ack);
        exp_t e;
        @(negedge clk);
        lk_valid  = lv;
        lk_tag    = TAG_W'(lt);
        lk_map_in = lm;
        wr_valid  = wv;
        wr_tag    = TAG_W'(wt);
        wr_map    = wm;
        flush_ack = ack;
        e.rq    = rq;
        e.hit   = lv && model.exists(lt);
        e.map   = e.hit ? model[lt] : lm;
        e.flush = m_flush;
        e.ready = !m_flush;
        sb.push_back(e);
        -> sample_ev;
        @(posedge clk);
        if (m_flush) begin
            if (ack) begin
                model.delete();
                m_flush = 0;
            end
        end else if (wv) begin
            model[wt] = wm;
            if (model.num() == ENTRIES) m_flush = 1;
        end
    endtask

    initial begin : monitor
        forever begin
            exp_t e;
            @(sample_ev);
            #1;
            e = sb.pop_front();
            total++;
            if (lk_hit !== e.hit || lk_map_out !== e.map ||
                flush_req !== e.flush || wr_ready !== e.ready) begin
                bad++;
                $display("FAIL %s: hit/map/flush/ready actual %b/%b/%b/%b expected %b/%b/%b/%b",
                         e.rq, lk_hit, lk_map_out, flush_req, wr_ready,
                         e.hit, e.map, e.flush, e.ready);
            end
        end
    end

    initial begin : watchdog
        #2000000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1 and R2: empty after reset, miss passes the request mapping
        step("R1", 1, 5, 3'b101, 0, 0, 0, 0);
        step("R2", 1, 'h10, 3'b010, 0, 0, 0, 0);
        // R4: same-cycle lookup of a tag being written sees old contents
        step("R4", 1, 'h10, 3'b001, 1, 'h10, 3'b110, 0);
        // R3: hit returns stored mapping (resident=1, way=2)
        step("R3", 1, 'h10, 3'b001, 0, 0, 0, 0);
        // R5: rewrite in place
        step("R5", 1, 'h10, 3'b000, 1, 'h10, 3'b011, 0);
        step("R5", 1, 'h10, 3'b000, 0, 0, 0, 0);
        // R10: no probe, no hit
        step("R10", 0, 'h10, 3'b100, 0, 0, 0, 0);
        // R9: stray ack keeps contents
        step("R9", 0, 0, 0, 0, 0, 0, 1);
        step("R9", 1, 'h10, 3'b000, 0, 0, 0, 0);
        // R5 and R6: fill the remaining slots with rewrites in between
        for (int i = 0; i < ENTRIES - 1; i++) begin
            if (i == 7) step("R5", 1, 'h100, 3'b000, 1, 'h100, 3'b111, 0);
            step("R6", 1, 'h100 + i, 3'b000, 1, 'h100 + i, 3'(i), 0);
        end
        // R6: flush pending, write stalled and held off
        step("R6", 1, 'h10, 3'b000, 1, 'h999, 3'b101, 0);
        step("R7", 1, 'h100, 3'b000, 0, 0, 0, 0);
        step("R7", 1, 'h10E, 3'b000, 1, 'h998, 3'b100, 0);
        step("R6", 1, 'h999, 3'b010, 0, 0, 0, 0);
        // R8: acknowledge clears everything in one cycle
        step("R8", 1, 'h105, 3'b000, 0, 0, 0, 1);
        step("R8", 1, 'h105, 3'b001, 0, 0, 0, 0);
        step("R8", 1, 'h10, 3'b001, 1, 'h200, 3'b100, 0);
        step("R8", 1, 'h200, 3'b000, 0, 0, 0, 0);
        step("R2", 1, 'h201, 3'b111, 0, 0, 0, 0);
        @(negedge clk);
        #2;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule